// File: doc/BRIEF.md
# ACPI Power-State Sequencing Controller

This block is the digital decision core of a memory power subsystem. It takes two active-low sleep requests and a set of supply and regulator status flags. From them it settles the subsystem into one of three power states: S0 (running), S3 (suspended, memory kept alive) or S5 (shut down). Power-up follows a fixed chain. The block first waits for the voltage reference. It then enables the auxiliary-supply monitor, then the main-supply monitor, and then starts the primary rail's soft-start. The termination rail and the secondary switching rail are released only once the primary rail reports that it is in regulation and that its soft-start has finished.

The analog parts of the subsystem are not modelled. Comparators, the reference, the ramp and the regulators appear only as digital status flags. All of these flags, and both requests, arrive asynchronously and are synchronized inside the block. For every rail and for both gate-drive pairs, the block produces an output-mode code that the analog drivers follow. It also produces a switching-frequency select for the primary rail.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset, and until a reference-good flag has been seen, the block reports mode S5 (code 2). All enables are low, the primary and secondary rails are OFF (code 0), the termination rail is HIZ (code 3), both gate pairs are LOW (code 0) and the frequency select is low.
- R2: Every status and request input passes through a two-flop synchronizer. A change driven before rising edge k first shows at the outputs after edge k+2.
- R3: The auxiliary monitor enable rises only after reference-good is seen. The main monitor enable rises only after auxiliary-good is seen while the auxiliary monitor is enabled.
- R4: From the main-monitor stage, the block enters S0 (code 0) and raises the primary soft-start enable only when main-good is high and both sleep requests are high. Otherwise it stays in S5 with both monitors enabled.
- R5: The termination enable and the secondary enable are high only in S0, and only once in-regulation and soft-start-done have both been seen high together.
- R6: In S0, a high-to-low change of the synchronized S3 request moves the block to S3 (code 1). In S3, a low-to-high change returns it to S0, where the dependent rails again wait for R5's condition. A request that is already low at S0 entry does not trigger S3, and main-good is ignored in S0 and S3.
- R7: A low S5 request in S0 or S3 returns the block to S5. Both monitors stay enabled and the rail enables clear. S0 is re-entered under the R4 condition.
- R8: Loss of reference-good in any state, or loss of auxiliary-good in any state past the auxiliary stage, forces S5, clears all rail enables and restarts the chain from the reference-wait stage.
- R9: Rail codes are OFF=0, NORMAL=1, STANDBY=2, HIZ=3, and gate codes are LOW=0, NORMAL=1, STANDBY=2. In the running S0 state, all rails and gates are NORMAL. While S0 is still ramping, only the primary rail and gate are NORMAL. In S3, the primary rail and gate are STANDBY, the termination rail is HIZ, the secondary rail is OFF and its gate is LOW. S5 is as in R1.
- R10: The frequency-select output is high exactly while the mode is S3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slp3_req_n | input | 1 | Suspend request, active low, asynchronous |
| slp5_req_n | input | 1 | Shutdown request, active low, asynchronous |
| ref_good | input | 1 | Voltage reference in regulation |
| aux_good | input | 1 | Auxiliary supply within limits |
| main_good | input | 1 | Main supply within limits |
| pri_inreg | input | 1 | Primary rail in regulation |
| ss_done | input | 1 | Primary soft-start interval complete |
| mode | output | 2 | Power state: S0=0, S3=1, S5=2 |
| aux_mon_en | output | 1 | Auxiliary supply monitor enable |
| main_mon_en | output | 1 | Main supply monitor enable |
| pri_ss_en | output | 1 | Primary rail soft-start enable |
| term_en | output | 1 | Termination rail enable |
| sec_en | output | 1 | Secondary switching rail enable |
| pri_rail_mode | output | 2 | Primary rail output code |
| term_rail_mode | output | 2 | Termination rail output code |
| sec_rail_mode | output | 2 | Secondary rail output code |
| pri_gate_mode | output | 2 | Primary gate-drive pair code |
| sec_gate_mode | output | 2 | Secondary gate-drive pair code |
| freq_dbl | output | 1 | Request doubled primary switching frequency |

## Verification
The bench aims at the ordering corners of the chain. It raises the later flags before the earlier ones, holds the suspend request low while main-good arrives, and raises in-regulation without soft-start-done. A design that skipped a stage or ignored a request level would enter S0 or release the dependent rails too early. It checks the sleep edges on the synchronized request. A level-triggered design would fall into S3 at S0 entry, or leave S3 while main-good has collapsed. It also removes the auxiliary supply and the reference in the running state. A design that only returned to an S5 state, without restarting, would keep the main monitor or a rail enable high. A per-clock model catches any latency that is off by one.

// File: rtl/pwr_seq_pkg.sv
// Package: shared encodings for the power-state sequencer.
// Assumes: a 2-bit mode code and 2-bit rail/gate output codes consumed by
// the analog drivers outside this block.
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        MODE_S0 = 2'd0,
        MODE_S3 = 2'd1,
        MODE_S5 = 2'd2
    } pmode_t;

    typedef enum logic [2:0] {
        ST_WAIT_REF  = 3'd0,
        ST_AUX_MON   = 3'd1,
        ST_MAIN_MON  = 3'd2,
        ST_S0_RAMP   = 3'd3,
        ST_S0_RUN    = 3'd4,
        ST_S3_SLEEP  = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        RAIL_OFF  = 2'd0,
        RAIL_NORM = 2'd1,
        RAIL_STBY = 2'd2,
        RAIL_HIZ  = 2'd3
    } rail_mode_t;

    typedef enum logic [1:0] {
        GATE_LOW  = 2'd0,
        GATE_NORM = 2'd1,
        GATE_STBY = 2'd2
    } gate_mode_t;

    // Bit positions of the synchronized status bus.
    localparam int IDX_S3N   = 0;
    localparam int IDX_S5N   = 1;
    localparam int IDX_REF   = 2;
    localparam int IDX_AUX   = 3;
    localparam int IDX_MAIN  = 4;
    localparam int IDX_INREG = 5;
    localparam int IDX_SSD   = 6;
    localparam int NUM_STAT  = 7;

    typedef struct packed {
        pmode_t     mode;
        logic       aux_mon_en;
        logic       main_mon_en;
        logic       pri_ss_en;
        logic       term_en;
        logic       sec_en;
        rail_mode_t pri_rail;
        rail_mode_t term_rail;
        rail_mode_t sec_rail;
        gate_mode_t pri_gate;
        gate_mode_t sec_gate;
        logic       freq_dbl;
    } seq_out_t;

endpackage

// File: rtl/sync_bank.sv
// Module: sync_bank
// A bank of multi-flop synchronizers, one chain per input bit.
// Assumes: each bit is an independent level; there is no bus coherency
// between bits. The reset value is per bit, so active-low requests reset
// to their inactive level.
module sync_bank #(
    parameter int              WIDTH   = 7,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift each input bit through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[LAST];
    end

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// The state register and transition logic of the sequencer.
// Assumes: all inputs are already synchronized. Suspend request edges are
// taken against the previous synchronized sample.
module seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_STAT-1:0] stat,
    output seq_state_t          state
);

    seq_state_t next_state;
    logic       s3n_prev;
    logic       s3_fall;
    logic       s3_rise;
    logic       ref_ok;
    logic       aux_ok;
    logic       s5n;
    logic       s3n;

    assign s3n     = stat[IDX_S3N];
    assign s5n     = stat[IDX_S5N];
    assign ref_ok  = stat[IDX_REF];
    assign aux_ok  = stat[IDX_AUX];
    assign s3_fall = s3n_prev & ~s3n;
    assign s3_rise = ~s3n_prev & s3n;

    // Remember the last synchronized suspend request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3n_prev <= 1'b1;
        end else begin
            s3n_prev <= s3n;
        end
    end

    // Choose the next state; supply loss outranks shutdown, which outranks sleep.
    always_comb begin
        next_state = state;
        if (!ref_ok) begin
            next_state = ST_WAIT_REF;
        end else if (!aux_ok && state != ST_WAIT_REF && state != ST_AUX_MON) begin
            next_state = ST_WAIT_REF;
        end else begin
            unique case (state)
                ST_WAIT_REF: next_state = ST_AUX_MON;
                ST_AUX_MON:  if (aux_ok) next_state = ST_MAIN_MON;
                ST_MAIN_MON: begin
                    if (stat[IDX_MAIN] && s3n && s5n) next_state = ST_S0_RAMP;
                end
                ST_S0_RAMP: begin
                    if (!s5n)                             next_state = ST_MAIN_MON;
                    else if (s3_fall)                     next_state = ST_S3_SLEEP;
                    else if (stat[IDX_INREG] && stat[IDX_SSD]) next_state = ST_S0_RUN;
                end
                ST_S0_RUN: begin
                    if (!s5n)         next_state = ST_MAIN_MON;
                    else if (s3_fall) next_state = ST_S3_SLEEP;
                end
                ST_S3_SLEEP: begin
                    if (!s5n)         next_state = ST_MAIN_MON;
                    else if (s3_rise) next_state = ST_S0_RAMP;
                end
                default: next_state = ST_WAIT_REF;
            endcase
        end
    end

    // Hold the current sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_REF;
        end else begin
            state <= next_state;
        end
    end

endmodule

// File: rtl/seq_out_decode.sv
// Module: seq_out_decode
// Maps the sequencer state onto the mode code, the enables and the per-rail
// output codes.
// Assumes: the outputs are a pure function of the state and need no extra
// register stage.
module seq_out_decode
    import pwr_seq_pkg::*;
(
    input  seq_state_t state,
    output seq_out_t   outs
);

    // Decode one state into the full output set.
    always_comb begin
        outs = '{mode: MODE_S5, aux_mon_en: 1'b0, main_mon_en: 1'b0,
                 pri_ss_en: 1'b0, term_en: 1'b0, sec_en: 1'b0,
                 pri_rail: RAIL_OFF, term_rail: RAIL_HIZ, sec_rail: RAIL_OFF,
                 pri_gate: GATE_LOW, sec_gate: GATE_LOW, freq_dbl: 1'b0};
        unique case (state)
            ST_WAIT_REF: ;
            ST_AUX_MON: outs.aux_mon_en = 1'b1;
            ST_MAIN_MON: begin
                outs.aux_mon_en  = 1'b1;
                outs.main_mon_en = 1'b1;
            end
            ST_S0_RAMP: begin
                outs.mode        = MODE_S0;
                outs.aux_mon_en  = 1'b1;
                outs.main_mon_en = 1'b1;
                outs.pri_ss_en   = 1'b1;
                outs.pri_rail    = RAIL_NORM;
                outs.pri_gate    = GATE_NORM;
            end
            ST_S0_RUN: begin
                outs.mode        = MODE_S0;
                outs.aux_mon_en  = 1'b1;
                outs.main_mon_en = 1'b1;
                outs.pri_ss_en   = 1'b1;
                outs.term_en     = 1'b1;
                outs.sec_en      = 1'b1;
                outs.pri_rail    = RAIL_NORM;
                outs.term_rail   = RAIL_NORM;
                outs.sec_rail    = RAIL_NORM;
                outs.pri_gate    = GATE_NORM;
                outs.sec_gate    = GATE_NORM;
            end
            ST_S3_SLEEP: begin
                outs.mode        = MODE_S3;
                outs.aux_mon_en  = 1'b1;
                outs.main_mon_en = 1'b1;
                outs.pri_rail    = RAIL_STBY;
                outs.pri_gate    = GATE_STBY;
                outs.freq_dbl    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwr_state_seq.sv
// Module: pwr_state_seq (top)
// The power-state sequencing controller. It synchronizes the asynchronous
// requests and status flags, runs the staged power-up chain and the sleep
// transitions, and drives the mode, enables and rail output codes.
// Assumes: all status inputs are levels from analog monitors that are
// stable for at least a few clocks.
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp3_req_n,
    input  logic       slp5_req_n,
    input  logic       ref_good,
    input  logic       aux_good,
    input  logic       main_good,
    input  logic       pri_inreg,
    input  logic       ss_done,
    output logic [1:0] mode,
    output logic       aux_mon_en,
    output logic       main_mon_en,
    output logic       pri_ss_en,
    output logic       term_en,
    output logic       sec_en,
    output logic [1:0] pri_rail_mode,
    output logic [1:0] term_rail_mode,
    output logic [1:0] sec_rail_mode,
    output logic [1:0] pri_gate_mode,
    output logic [1:0] sec_gate_mode,
    output logic       freq_dbl
);

    localparam logic [NUM_STAT-1:0] STAT_RST =
        NUM_STAT'((1 << IDX_S3N) | (1 << IDX_S5N));

    logic [NUM_STAT-1:0] stat_raw;
    logic [NUM_STAT-1:0] stat_sync;
    seq_state_t          state;
    seq_out_t            outs;

    // Gather the raw asynchronous inputs into one bus.
    always_comb begin
        stat_raw             = '0;
        stat_raw[IDX_S3N]    = slp3_req_n;
        stat_raw[IDX_S5N]    = slp5_req_n;
        stat_raw[IDX_REF]    = ref_good;
        stat_raw[IDX_AUX]    = aux_good;
        stat_raw[IDX_MAIN]   = main_good;
        stat_raw[IDX_INREG]  = pri_inreg;
        stat_raw[IDX_SSD]    = ss_done;
    end

    sync_bank #(
        .WIDTH   (NUM_STAT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (STAT_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stat_raw),
        .sync_out (stat_sync)
    );

    seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_sync),
        .state (state)
    );

    seq_out_decode u_dec (
        .state (state),
        .outs  (outs)
    );

    assign mode           = outs.mode;
    assign aux_mon_en     = outs.aux_mon_en;
    assign main_mon_en    = outs.main_mon_en;
    assign pri_ss_en      = outs.pri_ss_en;
    assign term_en        = outs.term_en;
    assign sec_en         = outs.sec_en;
    assign pri_rail_mode  = outs.pri_rail;
    assign term_rail_mode = outs.term_rail;
    assign sec_rail_mode  = outs.sec_rail;
    assign pri_gate_mode  = outs.pri_gate;
    assign sec_gate_mode  = outs.sec_gate;
    assign freq_dbl       = outs.freq_dbl;

endmodule

// File: rtl/pwr_state_seq_chk.sv
// Module: pwr_state_seq_chk
// Port-level protocol checks for pwr_state_seq, attached by bind.
// Assumes: it is connected only to the top's ports.
module pwr_state_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       aux_mon_en,
    input logic       main_mon_en,
    input logic       pri_ss_en,
    input logic       term_en,
    input logic       sec_en,
    input logic [1:0] term_rail_mode,
    input logic [1:0] sec_gate_mode,
    input logic       freq_dbl
);

    // R3
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_mon_en |-> aux_mon_en);

    // R4
    s0_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && $past(mode) == 2'd2) |-> $past(main_mon_en) && pri_ss_en);

    // R5
    dep_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_en || sec_en) |-> (mode == 2'd0 && pri_ss_en));

    // R6
    s3_from_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freq_dbl) |-> $past(mode) == 2'd0);

    // R8
    s5_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> !(pri_ss_en || term_en || sec_en));

    // R9
    s3_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (term_rail_mode == 2'd3 && sec_gate_mode == 2'd0));

    // R10
    freq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_dbl |-> mode == 2'd1);

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode),
    .aux_mon_en     (aux_mon_en),
    .main_mon_en    (main_mon_en),
    .pri_ss_en      (pri_ss_en),
    .term_en        (term_en),
    .sec_en         (sec_en),
    .term_rail_mode (term_rail_mode),
    .sec_gate_mode  (sec_gate_mode),
    .freq_dbl       (freq_dbl)
);

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp3_req_n = 1'b1, slp5_req_n = 1'b1;
    logic ref_good = 1'b0, aux_good = 1'b0, main_good = 1'b0;
    logic pri_inreg = 1'b0, ss_done = 1'b0;
    logic [1:0] mode, pri_rail_mode, term_rail_mode, sec_rail_mode, pri_gate_mode, sec_gate_mode;
    logic aux_mon_en, main_mon_en, pri_ss_en, term_en, sec_en, freq_dbl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_state_seq uut (
        .clk(clk), .rst_n(rst_n), .slp3_req_n(slp3_req_n), .slp5_req_n(slp5_req_n),
        .ref_good(ref_good), .aux_good(aux_good), .main_good(main_good),
        .pri_inreg(pri_inreg), .ss_done(ss_done), .mode(mode),
        .aux_mon_en(aux_mon_en), .main_mon_en(main_mon_en), .pri_ss_en(pri_ss_en),
        .term_en(term_en), .sec_en(sec_en), .pri_rail_mode(pri_rail_mode),
        .term_rail_mode(term_rail_mode), .sec_rail_mode(sec_rail_mode),
        .pri_gate_mode(pri_gate_mode), .sec_gate_mode(sec_gate_mode), .freq_dbl(freq_dbl)
    );

    // ---------------- behavioural reference model ----------------
    // Model stages: 0 wait-ref, 1 aux, 2 main, 3 ramp, 4 run, 5 sleep.
    int m_stage;
    bit m_s3_last;
    logic [6:0] dly[$];   // two-entry queue standing in for the synchronizer

    function automatic logic [6:0] pack_in();
        return {ss_done, pri_inreg, main_good, aux_good, ref_good, slp5_req_n, slp3_req_n};
    endfunction

    always @(posedge clk) begin
        logic [6:0] v;
        if (!rst_n) begin
            dly.delete();
            dly.push_back(7'b0000011);
            dly.push_back(7'b0000011);
            m_stage = 0;
            m_s3_last = 1;
        end else begin
            v = dly[0];
            if (!v[2]) m_stage = 0;
            else if (!v[3] && m_stage >= 2) m_stage = 0;
            else if (m_stage == 0) m_stage = 1;
            else if (m_stage == 1) begin
                if (v[3]) m_stage = 2;
            end else if (m_stage == 2) begin
                if (v[4] && v[0] && v[1]) m_stage = 3;
            end else if (!v[1]) m_stage = 2;
            else if (m_stage != 5 && m_s3_last && !v[0]) m_stage = 5;
            else if (m_stage == 5) begin
                if (!m_s3_last && v[0]) m_stage = 3;
            end else if (m_stage == 3 && v[5] && v[6]) m_stage = 4;
            m_s3_last = v[0];
            void'(dly.pop_front());
            dly.push_back(pack_in());
        end
    end

    // Expected output vector for a model stage.
    function automatic logic [17:0] exp_vec(int st);
        logic [1:0] md, pr, tr, sr, pg, sg;
        logic a, m, s, t, c, f;
        md = 2; a = st >= 1; m = st >= 2; s = 0; t = 0; c = 0; f = 0;
        pr = 0; tr = 3; sr = 0; pg = 0; sg = 0;
        if (st == 3 || st == 4) begin md = 0; s = 1; pr = 1; pg = 1; end
        if (st == 4) begin t = 1; c = 1; tr = 1; sr = 1; sg = 1; end
        if (st == 5) begin md = 1; pr = 2; pg = 2; f = 1; end
        return {md, a, m, s, t, c, pr, tr, sr, pg, sg, f};
    endfunction

    function automatic logic [17:0] act_vec();
        return {mode, aux_mon_en, main_mon_en, pri_ss_en, term_en, sec_en,
                pri_rail_mode, term_rail_mode, sec_rail_mode, pri_gate_mode, sec_gate_mode, freq_dbl};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R9 output codes, R10 frequency).
    always @(negedge clk) begin
        if (rst_n && !done) chk("R9", "model vector", int'(act_vec()), int'(exp_vec(m_stage)));
    end

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state, nothing happens without a reference
        chk("R1", "mode", mode, 2);
        chk("R1", "aux_mon_en", aux_mon_en, 0);
        chk("R1", "term_rail", term_rail_mode, 3);
        chk("R1", "freq_dbl", freq_dbl, 0);
        // R3: later flags before the reference do nothing
        aux_good = 1; main_good = 1;
        settle();
        chk("R3", "main_mon_en before ref", main_mon_en, 0);
        aux_good = 0; main_good = 0;
        settle();
        // R2: latency of exactly three edges
        ref_good = 1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R2", "aux_mon_en after 2 edges", aux_mon_en, 0);
        @(posedge clk); @(negedge clk);
        chk("R2", "aux_mon_en after 3 edges", aux_mon_en, 1);
        chk("R3", "main_mon_en without aux", main_mon_en, 0);
        // R4: entry blocked by a low suspend request
        slp3_req_n = 0; aux_good = 1; main_good = 1;
        settle();
        chk("R3", "main_mon_en", main_mon_en, 1);
        chk("R4", "mode with s3 low", mode, 2);
        chk("R4", "pri_ss_en with s3 low", pri_ss_en, 0);
        slp3_req_n = 1;
        settle();
        chk("R4", "mode", mode, 0);
        chk("R4", "pri_ss_en", pri_ss_en, 1);
        // R5: in-regulation alone is not enough
        pri_inreg = 1;
        settle();
        chk("R5", "term_en no ss_done", term_en, 0);
        chk("R9", "sec_rail ramp", sec_rail_mode, 0);
        ss_done = 1;
        settle();
        chk("R5", "term_en", term_en, 1);
        chk("R5", "sec_en", sec_en, 1);
        // R6: suspend edge into S3, supply collapse ignored
        slp3_req_n = 0;
        settle();
        chk("R6", "mode S3", mode, 1);
        chk("R10", "freq_dbl", freq_dbl, 1);
        chk("R9", "pri_rail stby", pri_rail_mode, 2);
        main_good = 0;
        settle();
        chk("R6", "mode S3 no main", mode, 1);
        slp3_req_n = 1;
        settle();
        chk("R6", "mode back S0", mode, 0);
        chk("R10", "freq_dbl S0", freq_dbl, 0);
        main_good = 1;
        // R7: shutdown request
        slp5_req_n = 0;
        settle();
        chk("R7", "mode S5", mode, 2);
        chk("R7", "main_mon_en kept", main_mon_en, 1);
        chk("R7", "term_en cleared", term_en, 0);
        slp5_req_n = 1;
        settle();
        chk("R7", "mode S0 again", mode, 0);
        // R8: auxiliary loss restarts the chain
        aux_good = 0;
        settle();
        chk("R8", "mode", mode, 2);
        chk("R8", "main_mon_en", main_mon_en, 0);
        chk("R8", "aux_mon_en", aux_mon_en, 1);
        aux_good = 1;
        settle();
        chk("R8", "recover S0", mode, 0);
        ref_good = 0;
        settle();
        chk("R8", "aux_mon_en no ref", aux_mon_en, 0);
        chk("R8", "sec_en no ref", sec_en, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule